// File: doc/BRIEF.md
# Parallel Addressable-LED Waveform Generator

This block drives several chains of single-wire addressable RGB LEDs at once, with one output lane per chain. Time is cut into bit slots of a fixed length. Each slot has three phases. At the start of the slot every enabled lane goes high. At a first compare point each lane takes its own data bit. At a second compare point every lane goes low. With the default timing, a slot is 60 cycles of a 48 MHz clock (1250 ns). The first compare point is at count 12 (250 ns) and the second is at count 31 (about 650 ns). A 0 bit therefore gives a short high pulse and a 1 bit gives a long one.

Software first fills a small frame buffer. Each buffer word holds one bit position for every lane: bit k of the word belongs to lane k. One word is consumed per slot, so adding lanes does not make the frame longer.

A start pulse begins a frame. The frame length in LEDs is taken from an input at that moment, and each LED uses 24 slots. The frame opens with one quiet slot in which every lane stays low. It ends with a guard time in which every lane is held low. After the guard time the block gives a one-cycle done pulse.

The buffer write port follows valid/ready rules. `wr_ready` is high only while the block is idle. A word is stored only on a cycle where both `wr_valid` and `wr_ready` are high. A writer that sees `wr_ready` low must hold its word and retry after `done`.

Top module: `led_lane_driver`

## Requirements
- R1: Out of reset and whenever the block is idle, every lane is low, `busy` is 0 and `done` is 0.
- R2: A slot lasts SLOT_CYC (60) cycles. In slot cycles 0 to 11, every enabled lane is high.
- R3: In slot cycles 12 to 30, enabled lane k equals bit k of the slot's buffer word.
- R4: In slot cycles 31 to 59, every lane is low.
- R5: Data slot j uses buffer word j, starting at address 0. A frame has `num_leds`×24 data slots. A `num_leds` value above MAX_LEDS (4) is treated as MAX_LEDS, and 0 gives no data slots.
- R6: For the first 60 cycles after a start is accepted, every lane is low (a quiet lead-in slot). Data slot 0 begins right after it.
- R7: After the last data slot, every lane stays low for GUARD_CYC (2640) cycles. Then `done` is high for exactly one cycle with `busy` still high, and `busy` drops on the following cycle.
- R8: A lane whose bit in `lane_en` is 0 stays low in every phase.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: `wr_ready` equals not `busy`. A write presented while busy does not change the buffer. A write accepted while idle is used by the next frame.
- R11: `busy` rises on the cycle after a start is accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 48 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Buffer write request |
| wr_ready | output | 1 | Buffer can accept a write (idle) |
| wr_addr | input | 7 | Buffer word address (slot index) |
| wr_data | input | 16 | Bit-transposed slot word, bit k for lane k |
| start | input | 1 | Begin a frame (taken only when idle) |
| num_leds | input | 3 | LEDs per chain for this frame, sampled at start |
| lane_en | input | 16 | Lane enable mask |
| busy | output | 1 | Frame or guard time in progress |
| done | output | 1 | One-cycle pulse at the end of the guard time |
| lane_out | output | 16 | Serial waveform, one bit per chain |

## Verification
The following properties are checked on every cycle inside the RTL:

- The lanes are quiet while idle, during the lead-in slot and during the guard time.
- Masked lanes never go high.
- The rising phase matches the enable mask.
- The slot counter stays within range and wraps.
- `done` is a single-cycle pulse followed by idle.
- `busy` rises only after a start.
- `wr_ready` is low while busy.

Other behaviours can only be shown by the bench's frames. These are the mapping of buffer words to slots and of bits to lanes, the clamping of the LED count, the exact guard length, and the fact that a start or a write presented mid-frame leaves both the next frame's timing and its data unchanged.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_DATA, ST_GUARD, ST_FIN} seq_state_t;
  typedef enum logic [1:0] {PH_RISE, PH_BIT, PH_FALL} slot_phase_t;
endpackage

// File: rtl/slot_timer.sv
module slot_timer
  import led_pkg::*;
#(
  parameter int SLOT_CYC = 60,
  parameter int T_BIT    = 12,
  parameter int T_FALL   = 31,
  localparam int CW      = $clog2(SLOT_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output slot_phase_t   phase,
  output logic          slot_last
);
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (cnt < CW'(T_BIT))       phase = PH_RISE;
    else if (cnt < CW'(T_FALL)) phase = PH_BIT;
    else                        phase = PH_FALL;
  end

  assign slot_last = run && (cnt == LAST);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_last |=> (cnt == '0));
endmodule

// File: rtl/frame_store.sv
module frame_store #(
  parameter int LANES = 16,
  parameter int DEPTH = 96,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [LANES-1:0] rdata
);
  logic [LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < (AW+1)'(DEPTH)))
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lane_shaper.sv
module lane_shaper
  import led_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             active,
  input  slot_phase_t      phase,
  input  logic [LANES-1:0] word,
  input  logic [LANES-1:0] en,
  output logic [LANES-1:0] out
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign out[k] = active && en[k] &&
                    ((phase == PH_RISE) || ((phase == PH_BIT) && word[k]));
  end
endmodule

// File: rtl/led_lane_driver.sv
module led_lane_driver
  import led_pkg::*;
#(
  parameter int LANES        = 16,
  parameter int MAX_LEDS     = 4,
  parameter int BITS_PER_LED = 24,
  parameter int SLOT_CYC     = 60,
  parameter int T_BIT        = 12,
  parameter int T_FALL       = 31,
  parameter int GUARD_CYC    = 2640,
  localparam int DEPTH       = MAX_LEDS * BITS_PER_LED,
  localparam int AW          = $clog2(DEPTH),
  localparam int NW          = $clog2(MAX_LEDS + 1),
  localparam int SW          = $clog2(DEPTH + 1),
  localparam int GW          = $clog2(GUARD_CYC),
  localparam int CW          = $clog2(SLOT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_data,
  input  logic             start,
  input  logic [NW-1:0]    num_leds,
  input  logic [LANES-1:0] lane_en,
  output logic             busy,
  output logic             done,
  output logic [LANES-1:0] lane_out
);
  seq_state_t       state;
  logic [AW-1:0]    slot_idx;
  logic [SW-1:0]    slot_total;
  logic [GW-1:0]    gcnt;
  logic [CW-1:0]    cnt;
  slot_phase_t      phase;
  logic             slot_last;
  logic [LANES-1:0] word;
  logic [NW-1:0]    n_cl;
  logic             run;

  assign n_cl = (num_leds > NW'(MAX_LEDS)) ? NW'(MAX_LEDS) : num_leds;
  assign run  = (state == ST_LEAD) || (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      slot_idx   <= '0;
      slot_total <= '0;
      gcnt       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          slot_total <= SW'(int'(n_cl) * BITS_PER_LED);
          slot_idx   <= '0;
          state      <= ST_LEAD;
        end
        ST_LEAD: if (slot_last) begin
          gcnt  <= '0;
          state <= (slot_total == '0) ? ST_GUARD : ST_DATA;
        end
        ST_DATA: if (slot_last) begin
          if ((SW'(slot_idx) + SW'(1)) == slot_total) begin
            gcnt  <= '0;
            state <= ST_GUARD;
          end else begin
            slot_idx <= slot_idx + 1'b1;
          end
        end
        ST_GUARD: begin
          if (gcnt == GW'(GUARD_CYC - 1)) state <= ST_FIN;
          else                            gcnt  <= gcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign wr_ready = (state == ST_IDLE);

  slot_timer #(.SLOT_CYC(SLOT_CYC), .T_BIT(T_BIT), .T_FALL(T_FALL)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cnt(cnt), .phase(phase), .slot_last(slot_last)
  );

  frame_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_valid && wr_ready), .waddr(wr_addr), .wdata(wr_data),
    .raddr(slot_idx), .rdata(word)
  );

  lane_shaper #(.LANES(LANES)) u_shape (
    .active(state == ST_DATA), .phase(phase), .word(word),
    .en(lane_en), .out(lane_out)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_out == '0) && !done);
  assert_rise_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) && (cnt < CW'(T_BIT)) |-> (lane_out == lane_en));
  assert_lead_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LEAD) |-> (lane_out == '0));
  assert_guard_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GUARD) |-> (lane_out == '0));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_masked_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out & ~lane_en) == '0);
  assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/sim_led_lane_driver.sv
module sim_led_lane_driver;
  localparam int LANES = 16, MAXL = 4, DEPTH = 96, SLOT = 60, TB = 12, TF = 31;
  localparam int GUARD = 2640;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, start = 0;
  logic [6:0] wr_addr = '0;
  logic [15:0] wr_data = '0, lane_en = '0;
  logic [2:0] num_leds = '0;
  logic wr_ready, busy, done;
  logic [15:0] lane_out;
  logic [15:0] exp_mem [DEPTH];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  led_lane_driver u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .num_leds(num_leds),
    .lane_en(lane_en), .busy(busy), .done(done), .lane_out(lane_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_out(int t, int ns, logic [15:0] en);
    int j, c;
    if (t < SLOT || t >= SLOT + SLOT * ns) return '0;
    j = (t - SLOT) / SLOT;
    c = (t - SLOT) % SLOT;
    if (c < TB) return en;
    if (c < TF) return exp_mem[j] & en;
    return '0;
  endfunction

  function automatic string req_of(int t, int ns);
    int c;
    if (t < SLOT) return "R6";
    if (t >= SLOT + SLOT * ns) return "R7";
    c = (t - SLOT) % SLOT;
    if (c < TB) return "R2";
    if (c < TF) return "R3 R5";
    return "R4";
  endfunction

  task automatic write_word(input int a, input logic [15:0] d);
    wr_valid = 1; wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    chk("R10 ready", {31'b0, wr_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
    exp_mem[a] = d;
  endtask

  task automatic run_frame(input int n, input logic [15:0] en, input bit poke);
    int ns, tend;
    ns = ((n > MAXL) ? MAXL : n) * 24;
    tend = SLOT + SLOT * ns + GUARD;
    lane_en = en; num_leds = 3'(n);
    start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t <= tend + 2; t++) begin
      if (t <= tend) begin
        chk(req_of(t, ns), lane_out, exp_out(t, ns, en));
        chk("R8", lane_out & ~en, '0);
      end
      if (t == 0) chk("R11 busy", {31'b0, busy}, 32'd1);
      if (t < tend) chk("R7 no early done", {31'b0, done}, 32'd0);
      if (t == tend) chk("R7 done+busy", {30'b0, done, busy}, 32'd3);
      if (t > tend) begin
        chk("R1 idle", {15'b0, busy, done, lane_out}, '0);
        chk("R9 no restart", {31'b0, busy}, 32'd0);
      end
      if (poke && t == 100) begin
        chk("R10 not ready", {31'b0, wr_ready}, 32'd0);
        start = 1; wr_valid = 1; wr_addr = 0; wr_data = ~exp_mem[0];
      end
      if (poke && t == 101) begin
        start = 0; wr_valid = 0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", {13'b0, busy, done, wr_ready, lane_out}, {13'b0, 3'b001, 16'h0});
    for (int a = 0; a < DEPTH; a++) write_word(a, 16'($urandom));
    run_frame(1, 16'hFFFF, 1'b0);
    run_frame(1, 16'h5A3C, 1'b1);
    run_frame(0, 16'hFFFF, 1'b0);
    run_frame(7, 16'hF00F, 1'b0);
    write_word(0, 16'hA5A5);
    write_word(1, 16'h0000);
    write_word(2, 16'hFFFF);
    for (int r = 0; r < 3; r++)
      run_frame(int'($urandom_range(1, 4)), 16'($urandom), r == 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule